// File: doc/BRIEF.md
# NAND Flash Strobe Timing Sequencer

This block runs the control strobes of a NAND flash device for short operations: a command or address byte, followed by a read strobe, a data-input write, or a wait on the device's ready line. The spacing between strobe edges is not fixed. It comes from a timing word kept for each chip select, and every delay field in that word is a compact 4-bit code that covers either 0 to 7 or 64 to 71 clock cycles.

A host starts an operation with a request/acknowledge handshake. The request carries the operation type, the chip-select index, a command or address byte, and a data byte. At the moment of acceptance the block copies the selected timing word and then steps through the phases of the operation. It pulses `done` when the operation finishes and raises `err` when the device stays busy for too long or when the chip select is not marked as NAND.

Timing words are written through a simple configuration port, and a lock input can freeze them. Each word can be read back at its own offset on the same port.

Top module: `nand_bus_sequencer`

## Requirements
- R1: After reset, every timing word reads 0; `cle` and `ale` are low; `we_n` and `re_n` are high; `done`, `err` and `io_oe` are low.
- R2: The timing word of chip select i sits at configuration byte offset i*0x14. Its stored fields are: bit 31, which marks the chip select as NAND; bits 27:24, write-to-busy delay; bits 19:16, ready-to-read delay; bits 11:8, address-to-read delay; bits 7:4, address-to-data delay; bits 3:0, command-to-read delay. All other bits read 0. A write to an offset that matches no chip select changes nothing, and such an offset reads 0.
- R3: While `cfg_lock` is high, configuration writes are ignored. Once `cfg_lock` is low again, writes take effect.
- R4: A delay code c stands for D = 64*c[3] + c[2:0] cycles, so the legal delays are 0 to 7 and 64 to 71 cycles.
- R5: Operation 0 (command then read) runs as follows: one cycle with `cle` high, `we_n` low and `io_out` equal to the command byte; then D(3:0)+1 idle cycles; then one cycle with `re_n` low; then `done` in the next cycle.
- R6: Operation 1 (address then read) runs like operation 0, but uses `ale` and the delay in bits 11:8.
- R7: Operation 2 (address then data) runs as follows: one `ale` cycle; then D(7:4)+1 idle cycles; then one cycle with `we_n` low and `io_out` equal to the data byte, so the rising edge of that data strobe comes D+2 cycles after `ale` falls. No read strobe is issued.
- R8: After the last write strobe of operations 2 and 3 rises, `rdy` is ignored for D(27:24)+1 cycles. After that it is sampled every cycle. For operation 2, `done` follows in the cycle after `rdy` is seen high.
- R9: Operation 3 (command, wait for ready, then read) runs as follows: one `cle` cycle; then the busy phase of R8; after `rdy` is seen high at a clock edge, D(19:16)+1 idle cycles; then one `re_n` cycle; then `done`.
- R10: If `rdy` stays low for BUSY_LIMIT sampled cycles, the operation ends with `done` and `err` high and no read strobe. `err` stays high until the next request is accepted.
- R11: A request to a chip select whose NAND bit is clear is acknowledged but drives no strobe. `done` and `err` go high in the next cycle.
- R12: `ack` is high in the same cycle as `req` only while the block is idle, and `done` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration byte offset |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_lock | input | 1 | Write lock; blocks writes while high |
| cfg_rdata | output | 32 | Timing word at `cfg_addr` |
| req | input | 1 | Operation request |
| req_op | input | 2 | Operation: 0 command-read, 1 address-read, 2 address-data, 3 command-wait-read |
| req_cs | input | CS_W | Chip-select index |
| req_byte | input | 8 | Command or address byte |
| req_data | input | 8 | Data byte for operation 2 |
| ack | output | 1 | Request accepted |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Busy timeout or non-NAND select |
| rdy | input | 1 | Device ready (high) / busy (low) |
| cle | output | 1 | Command latch strobe, active high |
| ale | output | 1 | Address latch strobe, active high |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| io_out | output | 8 | Byte driven to the device |
| io_oe | output | 1 | Output enable for `io_out` |

## Verification
The bench measures the spacing between strobe edges for both halves of the code space. With a zero code and with the 64-cycle codes, a design that decoded the top bit as 8 instead of 64, or that dropped or added the one-cycle base, would place the read strobe at the wrong edge. The busy phase is driven twice: once with `rdy` already high, which catches a design that samples during the write-to-busy window, and once with `rdy` raised late, which catches a wrong ready-to-read distance. A device that never becomes ready must end the operation after exactly the limit with `err` set, and that error must clear on the next accepted request. Locked writes, unmapped offsets and non-NAND selects must all leave the register contents or the strobes untouched.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

   typedef enum logic [1:0] {
      OP_CMD_RD     = 2'd0,
      OP_ADR_RD     = 2'd1,
      OP_ADR_WR     = 2'd2,
      OP_CMD_BSY_RD = 2'd3
   } nand_op_e;

   typedef struct packed {
      logic       nand_en;
      logic [3:0] twb;
      logic [3:0] trr;
      logic [3:0] tar;
      logic [3:0] tadl;
      logic [3:0] tclr;
   } tim_t;

   localparam int DLY_W = 7;

   // code -> cycles: bit3 weighs 64, bits 2:0 add 0..7
   function automatic logic [DLY_W-1:0] code_to_cycles(input logic [3:0] c);
      return {c[3], 3'b000, c[2:0]};
   endfunction

   function automatic tim_t unpack_word(input logic [31:0] w);
      tim_t t;
      t.nand_en = w[31];
      t.twb     = w[27:24];
      t.trr     = w[19:16];
      t.tar     = w[11:8];
      t.tadl    = w[7:4];
      t.tclr    = w[3:0];
      return t;
   endfunction

   function automatic logic [31:0] pack_word(input tim_t t);
      return {t.nand_en, 3'b000, t.twb, 4'h0, t.trr, 4'h0, t.tar, t.tadl, t.tclr};
   endfunction

endpackage

// File: rtl/nand_tim_regs.sv
module nand_tim_regs
   import nand_seq_pkg::*;
#(
   parameter int NUM_CS = 4,
   parameter int ADDR_W = 8,
   parameter int STRIDE = 20,
   localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   input  logic              lock,
   output logic [31:0]       rdata,
   input  logic [CS_W-1:0]   sel,
   output tim_t              sel_tim
);

   if (NUM_CS < 1 || NUM_CS > 8) begin : g_bad_count
      $error("nand_tim_regs: NUM_CS must be 1..8");
   end
   if (STRIDE * (NUM_CS - 1) >= (1 << ADDR_W)) begin : g_bad_map
      $error("nand_tim_regs: address space too small for the register map");
   end

   tim_t regs_q [NUM_CS];

   for (genvar i = 0; i < NUM_CS; i++) begin : g_word
      localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(i * STRIDE);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs_q[i] <= '0;
         else if (wr_en && !lock && addr == OFFS)
            regs_q[i] <= unpack_word(wdata);
      end

      // R3
      lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         lock |=> $stable(regs_q[i]));
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_CS; i++)
         if (addr == ADDR_W'(i * STRIDE))
            rdata = pack_word(regs_q[i]);
   end

   always_comb begin
      sel_tim = '0;
      for (int i = 0; i < NUM_CS; i++)
         if (int'(sel) == i)
            sel_tim = regs_q[i];
   end

endmodule

// File: rtl/nand_dly_timer.sv
module nand_dly_timer #(
   parameter int W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);

   if (W < 1) begin : g_bad_w
      $error("nand_dly_timer: W must be positive");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);

   // R4
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (zero && !load) |=> zero);

endmodule

// File: rtl/nand_busy_watch.sv
module nand_busy_watch #(
   parameter int LIMIT = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic rdy,
   output logic expire
);

   if (LIMIT == 0) begin : g_off
      assign expire = 1'b0;
   end else begin : g_on
      if (LIMIT < 2) begin : g_bad_limit
         $error("nand_busy_watch: LIMIT must be 0 or at least 2");
      end
      localparam int CNT_W = $clog2(LIMIT + 1);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt_q <= '0;
         else if (!active)
            cnt_q <= '0;
         else if (cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
      end

      assign expire = active && !rdy && (cnt_q == LAST);

      // R10
      cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (active && !rdy && cnt_q == LAST) |=> !active || cnt_q == LAST);
   end

endmodule

// File: rtl/nand_bus_sequencer.sv
module nand_bus_sequencer
   import nand_seq_pkg::*;
#(
   parameter int NUM_CS     = 4,
   parameter int ADDR_W     = 8,
   parameter int BUSY_LIMIT = 1024,
   localparam int CS_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
   localparam int STRIDE    = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   input  logic              cfg_lock,
   output logic [31:0]       cfg_rdata,
   input  logic              req,
   input  logic [1:0]        req_op,
   input  logic [CS_W-1:0]   req_cs,
   input  logic [7:0]        req_byte,
   input  logic [7:0]        req_data,
   output logic              ack,
   output logic              done,
   output logic              err,
   input  logic              rdy,
   output logic              cle,
   output logic              ale,
   output logic              we_n,
   output logic              re_n,
   output logic [7:0]        io_out,
   output logic              io_oe
);

   typedef enum logic [3:0] {
      S_IDLE, S_CMD, S_ADR, S_GAP_RD, S_RE, S_GAP_WD, S_WD,
      S_TWB, S_BUSY, S_TRR, S_FIN
   } st_e;

   st_e              state_q, nxt;
   nand_op_e         op_q;
   tim_t             tim_q, sel_tim;
   logic [7:0]       byte_q, data_q;
   logic             err_q, set_err;
   logic             tmr_load, tmr_zero, bw_expire;
   logic [DLY_W-1:0] tmr_val;

   nand_tim_regs #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .lock(cfg_lock), .rdata(cfg_rdata),
      .sel(req_cs), .sel_tim(sel_tim));

   nand_dly_timer #(.W(DLY_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
      .zero(tmr_zero));

   nand_busy_watch #(.LIMIT(BUSY_LIMIT)) u_bw (
      .clk(clk), .rst_n(rst_n), .active(state_q == S_BUSY), .rdy(rdy),
      .expire(bw_expire));

   assign ack = (state_q == S_IDLE) && req;

   always_comb begin
      nxt      = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      set_err  = 1'b0;
      unique case (state_q)
         S_IDLE: if (req) begin
            if (!sel_tim.nand_en) begin
               nxt     = S_FIN;
               set_err = 1'b1;
            end else if (req_op == OP_CMD_RD || req_op == OP_CMD_BSY_RD)
               nxt = S_CMD;
            else
               nxt = S_ADR;
         end
         S_CMD: begin
            tmr_load = 1'b1;
            if (op_q == OP_CMD_RD) begin
               nxt     = S_GAP_RD;
               tmr_val = code_to_cycles(tim_q.tclr);
            end else begin
               nxt     = S_TWB;
               tmr_val = code_to_cycles(tim_q.twb);
            end
         end
         S_ADR: begin
            tmr_load = 1'b1;
            if (op_q == OP_ADR_RD) begin
               nxt     = S_GAP_RD;
               tmr_val = code_to_cycles(tim_q.tar);
            end else begin
               nxt     = S_GAP_WD;
               tmr_val = code_to_cycles(tim_q.tadl);
            end
         end
         S_GAP_RD: if (tmr_zero) nxt = S_RE;
         S_RE:     nxt = S_FIN;
         S_GAP_WD: if (tmr_zero) nxt = S_WD;
         S_WD: begin
            nxt      = S_TWB;
            tmr_load = 1'b1;
            tmr_val  = code_to_cycles(tim_q.twb);
         end
         S_TWB: if (tmr_zero) nxt = S_BUSY;
         S_BUSY: begin
            if (rdy) begin
               if (op_q == OP_CMD_BSY_RD) begin
                  nxt      = S_TRR;
                  tmr_load = 1'b1;
                  tmr_val  = code_to_cycles(tim_q.trr);
               end else
                  nxt = S_FIN;
            end else if (bw_expire) begin
               nxt     = S_FIN;
               set_err = 1'b1;
            end
         end
         S_TRR: if (tmr_zero) nxt = S_RE;
         S_FIN: nxt = S_IDLE;
         default: nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         op_q    <= OP_CMD_RD;
         tim_q   <= '0;
         byte_q  <= '0;
         data_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         state_q <= nxt;
         if (ack) begin
            op_q   <= nand_op_e'(req_op);
            tim_q  <= sel_tim;
            byte_q <= req_byte;
            data_q <= req_data;
         end
         if (set_err)
            err_q <= 1'b1;
         else if (ack)
            err_q <= 1'b0;
      end
   end

   assign cle   = (state_q == S_CMD);
   assign ale   = (state_q == S_ADR);
   assign we_n  = !(state_q == S_CMD || state_q == S_ADR || state_q == S_WD);
   assign re_n  = (state_q != S_RE);
   assign io_oe = !we_n;
   assign done  = (state_q == S_FIN);
   assign err   = err_q;
   assign io_out = (state_q == S_WD) ? data_q : (io_oe ? byte_q : 8'h00);

   // R5
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cle && ale) && !(!we_n && !re_n));

   // R5
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !re_n |=> re_n);

   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R12
   ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);

   // R11
   nonnand_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !sel_tim.nand_en) |=> done && err && we_n && re_n);

   // R10
   timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bw_expire && state_q == S_BUSY) |=> done && err);

endmodule

// File: tb/nand_bus_sequencer_test.sv
module nand_bus_sequencer_test;

   localparam int CLK_PERIOD = 10;
   localparam int LIM        = 40;

   logic        clk = 0, rst_n = 0;
   logic        cfg_we = 0, cfg_lock = 0;
   logic [7:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0, cfg_rdata;
   logic        req = 0, rdy = 0;
   logic [1:0]  req_op = '0, req_cs = '0;
   logic [7:0]  req_byte = '0, req_data = '0, io_out;
   logic        ack, done, err, cle, ale, we_n, re_n, io_oe;

   int n_chk = 0, n_fail = 0, cyc = 0;
   int t_cle, t_ale, t_re, t_wd, t_done, t_start, re_cnt;
   logic [7:0] cmd_io, ale_io, wd_io;
   logic err_d, ack_seen, strobe_seen, done_after;

   nand_bus_sequencer #(.BUSY_LIMIT(LIM)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_lock(cfg_lock), .cfg_rdata(cfg_rdata),
      .req(req), .req_op(req_op), .req_cs(req_cs), .req_byte(req_byte),
      .req_data(req_data), .ack(ack), .done(done), .err(err), .rdy(rdy),
      .cle(cle), .ale(ale), .we_n(we_n), .re_n(re_n), .io_out(io_out),
      .io_oe(io_oe));

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_addr = a; cfg_wdata = d; cfg_we = 1;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic run_op(input logic [1:0] op, input logic [1:0] cs,
                         input logic [7:0] b, input logic [7:0] d, input int rdy_rel);
      int rdy_at;
      t_cle = -1; t_ale = -1; t_re = -1; t_wd = -1; t_done = -1; re_cnt = 0;
      strobe_seen = 0; err_d = 0;
      @(negedge clk);
      t_start = cyc;
      rdy_at = cyc + rdy_rel;
      rdy = (cyc >= rdy_at);
      req = 1; req_op = op; req_cs = cs; req_byte = b; req_data = d;
      #1 ack_seen = ack;
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         req = 0;
         rdy = (cyc >= rdy_at);
         #1;
         if (cle) begin t_cle = cyc; cmd_io = io_out; end
         if (ale) begin t_ale = cyc; ale_io = io_out; end
         if (!we_n && !cle && !ale) begin t_wd = cyc; wd_io = io_out; end
         if (!re_n) begin
            if (t_re < 0) t_re = cyc;
            re_cnt++;
         end
         if (cle || ale || !we_n || !re_n) strobe_seen = 1;
         if (done) begin t_done = cyc; err_d = err; break; end
      end
      @(negedge clk);
      #1 done_after = done;
      rdy = 0;
   endtask

   task automatic t_reset;
      logic [31:0] r;
      for (int i = 0; i < 4; i++) begin
         cfg_read(8'(i * 20), r);
         chk("R1 timing word after reset", r, 0);
      end
      chk("R1 strobes idle", {cle, ale, we_n, re_n, done, err, io_oe}, 7'b0011000);
   endtask

   task automatic t_regmap;
      logic [31:0] r;
      cfg_write(8'h14, 32'hFFFF_FFFF);
      cfg_read(8'h14, r);
      chk("R2 unused bits read zero", r, 32'h8F0F_0FFF);
      cfg_read(8'h00, r);
      chk("R2 neighbour untouched", r, 0);
      cfg_write(8'h04, 32'hFFFF_FFFF);
      cfg_read(8'h00, r);
      chk("R2 unmapped write ignored", r, 0);
      cfg_read(8'h04, r);
      chk("R2 unmapped offset reads zero", r, 0);
      cfg_write(8'h00, 32'h8401_0532);
      cfg_read(8'h00, r);
      chk("R2 chip select 0 word", r, 32'h8401_0532);
      cfg_write(8'h28, 32'h8000_1809);
      cfg_read(8'h28, r);
      chk("R2 chip select 2 word", r, 32'h8000_0809);
   endtask

   task automatic t_lock;
      logic [31:0] r;
      cfg_lock = 1;
      cfg_write(8'h14, 32'h0);
      cfg_read(8'h14, r);
      chk("R3 locked write ignored", r, 32'h8F0F_0FFF);
      cfg_lock = 0;
      cfg_write(8'h14, 32'h8000_0F00);
      cfg_read(8'h14, r);
      chk("R3 write after unlock", r, 32'h8000_0F00);
   endtask

   task automatic t_cmd_read;
      run_op(2'd0, 2'd0, 8'h30, 8'h00, 0);
      chk("R12 ack with request", ack_seen, 1);
      chk("R5 command byte", cmd_io, 8'h30);
      chk("R5 read strobe after CLE", t_re - t_cle, 4);
      chk("R5 read strobe width", re_cnt, 1);
      chk("R5 done after read", t_done - t_re, 1);
      chk("R12 done one cycle", done_after, 0);
   endtask

   task automatic t_addr_read;
      run_op(2'd1, 2'd0, 8'h5A, 8'h00, 0);
      chk("R6 address byte", ale_io, 8'h5A);
      chk("R6 read strobe after ALE", t_re - t_ale, 7);
      chk("R6 no command latch", t_cle, -1);
   endtask

   task automatic t_long_codes;
      run_op(2'd0, 2'd2, 8'h11, 8'h00, 0);
      chk("R4 code 9 gives 65", t_re - t_cle, 67);
      run_op(2'd1, 2'd2, 8'h22, 8'h00, 0);
      chk("R4 code 8 gives 64", t_re - t_ale, 66);
      run_op(2'd1, 2'd1, 8'h33, 8'h00, 0);
      chk("R4 code 15 gives 71", t_re - t_ale, 73);
   endtask

   task automatic t_addr_data;
      run_op(2'd2, 2'd0, 8'h44, 8'hC3, 0);
      chk("R7 data strobe after ALE", t_wd - t_ale, 5);
      chk("R7 data byte", wd_io, 8'hC3);
      chk("R7 no read strobe", t_re, -1);
      chk("R8 done after busy gap", t_done - t_wd, 7);
      chk("R8 no error", err_d, 0);
   endtask

   task automatic t_cmd_busy;
      run_op(2'd3, 2'd0, 8'h70, 8'h00, 0);
      chk("R9 read after ready already high", t_re - t_cle, 9);
      chk("R9 done after read", t_done - t_re, 1);
      run_op(2'd3, 2'd0, 8'h70, 8'h00, 25);
      chk("R9 read after late ready", t_re - (t_start + 25), 3);
      chk("R8 late ready no error", err_d, 0);
   endtask

   task automatic t_timeout;
      run_op(2'd2, 2'd0, 8'h44, 8'h99, 100000);
      chk("R10 timeout end cycle", t_done - t_wd, 46);
      chk("R10 timeout error", err_d, 1);
      chk("R10 no read strobe", t_re, -1);
      #1 chk("R10 error held", err, 1);
      run_op(2'd0, 2'd0, 8'h30, 8'h00, 0);
      chk("R10 error cleared by next request", err_d, 0);
   endtask

   task automatic t_nonnand;
      run_op(2'd0, 2'd3, 8'h30, 8'h00, 0);
      chk("R11 request acknowledged", ack_seen, 1);
      chk("R11 no strobe", strobe_seen, 0);
      chk("R11 done next cycle", t_done - t_start, 1);
      chk("R11 error", err_d, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1 t_reset();
      rst_n = 1;
      t_reset();
      t_regmap();
      t_lock();
      t_cmd_read();
      t_addr_read();
      t_long_codes();
      t_addr_data();
      t_cmd_busy();
      t_timeout();
      t_nonnand();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule